// File: doc/BRIEF.md
# Framebuffer Control Register Bank

This block is the software-visible configuration store of a display framebuffer engine. A host reaches it over a plain synchronous word bus with a read strobe, a write strobe, a byte address, write data, registered read data and an error pulse. Behind that bus sit fourteen 32-bit slots. They hold the line and frame timing values, the framebuffer start address, a hold bit that keeps the display off, a burst length and two general words that are only stored.

The bank checks every access. A misaligned word, an address past the last slot, a write to the read-only copy of the start address, and a start address that is not on a 32-byte boundary are each refused, and the error pulse reports the refusal. A start address that is accepted is trimmed by a mask parameter and announced with a one-cycle invalidate pulse. A change to the hold bit or to either active size announces a geometry change, but only when the display stays enabled afterwards. The stored values drive a downstream scan generator directly, and the start address reaches it with a fixed offset added.

Top module: `vidfb_csr`

## Requirements
- R1: The slot index is the byte address shifted right by two. The slots, by index 0 to 13, are: control, horizontal active, horizontal sync begin, horizontal sync end, horizontal total, vertical active, vertical sync begin, vertical sync end, vertical total, start address, start-address view, burst length, display-link word, pixel-clock word. A legal write to a writable slot is returned unchanged by a later read of that slot.
- R2: `disp_en` is high exactly while bit 0 (the hold bit) of the control slot is 0. It can rise only after a write to the control slot.
- R3: After reset the control slot is 1, horizontal active is 640, vertical active is 480, and every other slot is 0.
- R4: A write to the start-address slot whose data has any of bits 4:0 set leaves the slot unchanged, raises `bus_err` and gives no invalidate pulse.
- R5: An accepted write to the start-address slot stores the data ANDed with `FB_MASK` and raises `inval_pulse` for one cycle.
- R6: A read of the start-address view (index 10) returns the start-address slot. A write to the view changes nothing and raises `bus_err`.
- R7: A write to the control, horizontal active or vertical active slot raises `resize_pulse` for one cycle when the hold bit is 0 after that write. Otherwise the write gives no pulse.
- R8: An access whose address bits 1:0 are not 00 is illegal. A read returns 0, a write changes no slot, and `bus_err` is raised.
- R9: An access to an index above 13 is illegal. A read returns 0, a write changes no slot, and `bus_err` is raised.
- R10: `bus_rdata`, `bus_err`, `resize_pulse` and `inval_pulse` are registered. Each answers the strobe sampled at one rising edge and is valid from that edge until the next. `bus_rdata` is 0 in any cycle that answers no read.
- R11: The timing outputs and `burst_len` always equal their slots. `fb_base` equals the start-address slot plus `FB_OFFSET`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse for a refused access |
| disp_en | output | 1 | Display enabled (hold bit clear) |
| resize_pulse | output | 1 | One-cycle geometry-change pulse |
| inval_pulse | output | 1 | One-cycle start-address-change pulse |
| h_active | output | 32 | Horizontal active pixels |
| h_sync_beg | output | 32 | Horizontal sync begin |
| h_sync_end | output | 32 | Horizontal sync end |
| h_total | output | 32 | Horizontal total |
| v_active | output | 32 | Vertical active lines |
| v_sync_beg | output | 32 | Vertical sync begin |
| v_sync_end | output | 32 | Vertical sync end |
| v_total | output | 32 | Vertical total |
| fb_base | output | 32 | Start address plus offset |
| burst_len | output | 32 | Burst length |

## Verification
Every bus response (read data, error, resize and invalidate) is due in the cycle right after the rising edge that samples the strobe. The bench drives the strobes at the falling edge and samples one time unit after the next rising edge, then drops the strobes so that each response is seen exactly once. Slot contents and the direct outputs change at that same edge, so a read-back vector or an output check placed after a write looks at the settled value. An idle cycle after an illegal access confirms that the error and the read data return to zero.

// File: rtl/vidfb_csr_pkg.sv
// Package: shared slot indices, widths and reset values for the framebuffer
// control bank. Assumes a 32-bit data path and a fixed map of fourteen slots.
package vidfb_csr_pkg;

    localparam int DATA_W       = 32;
    localparam int NUM_REGS     = 14;
    localparam int IDX_W        = $clog2(NUM_REGS);
    localparam int ALIGN_BITS   = 5;   // start address must sit on 2**ALIGN_BITS bytes
    localparam int CTL_HOLD_BIT = 0;
    localparam logic [DATA_W-1:0] H_ACT_RST = 32'd640;
    localparam logic [DATA_W-1:0] V_ACT_RST = 32'd480;

    typedef enum logic [IDX_W-1:0] {
        IX_CTL       = 4'd0,
        IX_H_ACT     = 4'd1,
        IX_H_SYB     = 4'd2,
        IX_H_SYE     = 4'd3,
        IX_H_TOT     = 4'd4,
        IX_V_ACT     = 4'd5,
        IX_V_SYB     = 4'd6,
        IX_V_SYE     = 4'd7,
        IX_V_TOT     = 4'd8,
        IX_BASE      = 4'd9,
        IX_BASE_VIEW = 4'd10,
        IX_BURST     = 4'd11,
        IX_LINK      = 4'd12,
        IX_PIXCLK    = 4'd13
    } slot_e;

    // Reset value of a slot given its index.
    function automatic logic [DATA_W-1:0] reset_value(input int idx);
        if (idx == int'(IX_CTL))        return 32'd1;
        else if (idx == int'(IX_H_ACT)) return H_ACT_RST;
        else if (idx == int'(IX_V_ACT)) return V_ACT_RST;
        else                            return '0;
    endfunction

endpackage

// File: rtl/vidfb_csr_decode.sv
// Module: address decoder. It turns a byte address into a slot index, a
// one-hot select and a legality flag. Assumes word access only: any address
// with nonzero low two bits, or past the last slot, is not a hit.
module vidfb_csr_decode
    import vidfb_csr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [IDX_W-1:0]    idx,
    output logic                hit,
    output logic [NUM_REGS-1:0] sel
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              aligned;

    // Split the byte address into word index and alignment.
    always_comb begin
        word    = addr[ADDR_W-1:2];
        aligned = (addr[1:0] == 2'b00);
        hit     = aligned && (word < WORD_W'(NUM_REGS));
        idx     = word[IDX_W-1:0];
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
        assign sel[i] = hit && (word == WORD_W'(i));
    end

endmodule

// File: rtl/vidfb_csr_base.sv
// Module: start-address slot. It accepts only 32-byte aligned data, trims
// accepted data with FB_MASK and pulses invalidate for one cycle. Assumes the
// caller presents wr_en only for a legal write aimed at this slot.
module vidfb_csr_base
    import vidfb_csr_pkg::*;
#(
    parameter logic [DATA_W-1:0] FB_MASK = 32'hFFFF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] base_q,
    output logic              inval_q,
    output logic              reject
);
    logic misalign;

    // Flag data that is off the required boundary.
    always_comb begin
        misalign = |wdata[ALIGN_BITS-1:0];
        reject   = wr_en && misalign;
    end

    // Store the accepted address and raise the invalidate pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            inval_q <= 1'b0;
        end else begin
            inval_q <= wr_en && !misalign;
            if (wr_en && !misalign) base_q <= wdata & FB_MASK;
        end
    end

    assert_base_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && misalign) |=> ($stable(base_q) && !inval_q));

    assert_base_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !misalign) |=> (inval_q && base_q == ($past(wdata) & FB_MASK)));

endmodule

// File: rtl/vidfb_csr_bank.sv
// Module: general slot storage and the geometry-change pulse. Each slot is a
// flop with its reset value. The start-address slot and its view are held
// elsewhere and read as zero here. Assumes wr_sel is already qualified.
module vidfb_csr_bank
    import vidfb_csr_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_REGS-1:0]              wr_sel,
    input  logic [DATA_W-1:0]                wdata,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q,
    output logic                             resize_q
);
    logic [DATA_W-1:0] store_q [NUM_REGS];
    logic              touch;
    logic              hold_after;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        localparam bit STORED = (i != int'(IX_BASE)) && (i != int'(IX_BASE_VIEW));
        // Hold one slot, loaded on its own select.
        always_ff @(posedge clk) begin
            if (!rst_n)                  store_q[i] <= reset_value(i);
            else if (STORED && wr_sel[i]) store_q[i] <= wdata;
        end
        assign regs_q[i] = store_q[i];
    end

    // Work out the hold bit as it stands once this write lands.
    always_comb begin
        touch      = wr_sel[IX_CTL] | wr_sel[IX_H_ACT] | wr_sel[IX_V_ACT];
        hold_after = wr_sel[IX_CTL] ? wdata[CTL_HOLD_BIT]
                                    : store_q[IX_CTL][CTL_HOLD_BIT];
    end

    // Pulse on a geometry write that leaves the display running.
    always_ff @(posedge clk) begin
        if (!rst_n) resize_q <= 1'b0;
        else        resize_q <= touch && !hold_after;
    end

    assert_resize_running_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resize_q |-> !store_q[IX_CTL][CTL_HOLD_BIT]);

    assert_enable_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(store_q[IX_CTL][CTL_HOLD_BIT]) |-> $past(wr_sel[IX_CTL]));

endmodule

// File: rtl/vidfb_csr.sv
// Module: framebuffer control bank top. It decodes the word bus, routes
// writes, refuses illegal accesses with a one-cycle error, registers read
// data and presents the stored configuration to the scan generator.
// Assumes reads and writes complete in one cycle with no wait states.
module vidfb_csr
    import vidfb_csr_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [DATA_W-1:0] FB_MASK   = 32'hFFFF_FFFF,
    parameter logic [DATA_W-1:0] FB_OFFSET = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic              disp_en,
    output logic              resize_pulse,
    output logic              inval_pulse,
    output logic [DATA_W-1:0] h_active,
    output logic [DATA_W-1:0] h_sync_beg,
    output logic [DATA_W-1:0] h_sync_end,
    output logic [DATA_W-1:0] h_total,
    output logic [DATA_W-1:0] v_active,
    output logic [DATA_W-1:0] v_sync_beg,
    output logic [DATA_W-1:0] v_sync_end,
    output logic [DATA_W-1:0] v_total,
    output logic [DATA_W-1:0] fb_base,
    output logic [DATA_W-1:0] burst_len
);
    logic [IDX_W-1:0]                    dec_idx;
    logic                                dec_hit;
    logic [NUM_REGS-1:0]                 dec_sel;
    logic                                wr_legal;
    logic [NUM_REGS-1:0]                 bank_sel;
    logic                                base_wr;
    logic                                base_reject;
    logic [DATA_W-1:0]                   base_q;
    logic [NUM_REGS-1:0][DATA_W-1:0]     bank_q;
    logic                                err_now;
    logic [DATA_W-1:0]                   rd_val;

    vidfb_csr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .idx  (dec_idx),
        .hit  (dec_hit),
        .sel  (dec_sel)
    );

    // Qualify writes: the view slot is read-only.
    always_comb begin
        wr_legal = bus_wr && dec_hit && !dec_sel[IX_BASE_VIEW];
        bank_sel = wr_legal ? dec_sel : '0;
        base_wr  = wr_legal && dec_sel[IX_BASE];
    end

    vidfb_csr_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sel   (bank_sel),
        .wdata    (bus_wdata),
        .regs_q   (bank_q),
        .resize_q (resize_pulse)
    );

    vidfb_csr_base #(.FB_MASK(FB_MASK)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (base_wr),
        .wdata   (bus_wdata),
        .base_q  (base_q),
        .inval_q (inval_pulse),
        .reject  (base_reject)
    );

    // Gather every reason for refusing this cycle's access.
    always_comb begin
        err_now = ((bus_rd || bus_wr) && !dec_hit)
                || (bus_wr && dec_sel[IX_BASE_VIEW])
                || base_reject;
    end

    // Select read data; both start-address slots return the stored address.
    always_comb begin
        if (!dec_hit)                                   rd_val = '0;
        else if (dec_sel[IX_BASE] || dec_sel[IX_BASE_VIEW]) rd_val = base_q;
        else                                            rd_val = bank_q[dec_idx];
    end

    // Register the bus response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_rdata <= bus_rd ? rd_val : '0;
            bus_err   <= err_now;
        end
    end

    // Present stored configuration to the scan generator.
    always_comb begin
        disp_en    = !bank_q[IX_CTL][CTL_HOLD_BIT];
        h_active   = bank_q[IX_H_ACT];
        h_sync_beg = bank_q[IX_H_SYB];
        h_sync_end = bank_q[IX_H_SYE];
        h_total    = bank_q[IX_H_TOT];
        v_active   = bank_q[IX_V_ACT];
        v_sync_beg = bank_q[IX_V_SYB];
        v_sync_end = bank_q[IX_V_SYE];
        v_total    = bank_q[IX_V_TOT];
        burst_len  = bank_q[IX_BURST];
        fb_base    = base_q + FB_OFFSET;
    end

    assert_bad_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !dec_hit) |=> (bus_rdata == '0 && bus_err));

    assert_view_write_refused_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && dec_sel[IX_BASE_VIEW]) |=> (bus_err && $stable(base_q)));

    assert_idle_no_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd) |=> (bus_rdata == '0));

endmodule

// File: tb/test_vidfb_csr.sv
// Bench: a vector table walked by one loop, then directed checks for reset,
// enable, outputs and the error pulse width.
module test_vidfb_csr;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] MASK = 32'h00FF_FFFF;
    localparam logic [31:0] OFFS = 32'h0000_0100;

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp_rd;
        logic        exp_err;
        logic        exp_rsz;
        logic        exp_inv;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 30;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 8'h00, 32'd0,    32'd1,    1'b0, 1'b0, 1'b0, 4'd3},  // R3 control
        '{1'b0, 8'h04, 32'd0,    32'd640,  1'b0, 1'b0, 1'b0, 4'd3},  // R3
        '{1'b0, 8'h14, 32'd0,    32'd480,  1'b0, 1'b0, 1'b0, 4'd3},  // R3
        '{1'b0, 8'h08, 32'd0,    32'd0,    1'b0, 1'b0, 1'b0, 4'd3},  // R3
        '{1'b0, 8'h24, 32'd0,    32'd0,    1'b0, 1'b0, 1'b0, 4'd3},  // R3
        '{1'b1, 8'h04, 32'd800,  32'd0,    1'b0, 1'b0, 1'b0, 4'd7},  // R7 held
        '{1'b0, 8'h04, 32'd0,    32'd800,  1'b0, 1'b0, 1'b0, 4'd1},  // R1
        '{1'b1, 8'h00, 32'd0,    32'd0,    1'b0, 1'b1, 1'b0, 4'd7},  // R7 release
        '{1'b1, 8'h14, 32'd600,  32'd0,    1'b0, 1'b1, 1'b0, 4'd7},  // R7
        '{1'b0, 8'h14, 32'd0,    32'd600,  1'b0, 1'b0, 1'b0, 4'd1},  // R1
        '{1'b1, 8'h08, 32'd656,  32'd0,    1'b0, 1'b0, 1'b0, 4'd7},  // R7 no pulse
        '{1'b0, 8'h08, 32'd0,    32'd656,  1'b0, 1'b0, 1'b0, 4'd1},  // R1
        '{1'b1, 8'h24, 32'h1000_0020, 32'd0, 1'b0, 1'b0, 1'b1, 4'd5},// R5 masked
        '{1'b0, 8'h28, 32'd0,    32'h20,   1'b0, 1'b0, 1'b0, 4'd6},  // R6 view
        '{1'b1, 8'h24, 32'h44,   32'd0,    1'b1, 1'b0, 1'b0, 4'd4},  // R4
        '{1'b0, 8'h24, 32'd0,    32'h20,   1'b0, 1'b0, 1'b0, 4'd4},  // R4 kept
        '{1'b1, 8'h28, 32'd5,    32'd0,    1'b1, 1'b0, 1'b0, 4'd6},  // R6
        '{1'b0, 8'h28, 32'd0,    32'h20,   1'b0, 1'b0, 1'b0, 4'd6},  // R6
        '{1'b0, 8'h38, 32'd0,    32'd0,    1'b1, 1'b0, 1'b0, 4'd9},  // R9
        '{1'b1, 8'h3C, 32'd1,    32'd0,    1'b1, 1'b0, 1'b0, 4'd9},  // R9
        '{1'b0, 8'h06, 32'd0,    32'd0,    1'b1, 1'b0, 1'b0, 4'd8},  // R8
        '{1'b1, 8'h05, 32'd999,  32'd0,    1'b1, 1'b0, 1'b0, 4'd8},  // R8
        '{1'b0, 8'h04, 32'd0,    32'd800,  1'b0, 1'b0, 1'b0, 4'd8},  // R8 kept
        '{1'b1, 8'h2C, 32'd7,    32'd0,    1'b0, 1'b0, 1'b0, 4'd1},  // R1
        '{1'b0, 8'h2C, 32'd0,    32'd7,    1'b0, 1'b0, 1'b0, 4'd1},  // R1
        '{1'b1, 8'h34, 32'hABCD, 32'd0,    1'b0, 1'b0, 1'b0, 4'd1},  // R1
        '{1'b0, 8'h34, 32'd0,    32'hABCD, 1'b0, 1'b0, 1'b0, 4'd1},  // R1
        '{1'b1, 8'h00, 32'd1,    32'd0,    1'b0, 1'b0, 1'b0, 4'd7},  // R7 hold set
        '{1'b1, 8'h04, 32'd1024, 32'd0,    1'b0, 1'b0, 1'b0, 4'd7},  // R7 held
        '{1'b0, 8'h00, 32'd0,    32'd1,    1'b0, 1'b0, 1'b0, 4'd2}   // R2 readback
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err, disp_en, resize_pulse, inval_pulse;
    logic [31:0] h_active, h_sync_beg, h_sync_end, h_total;
    logic [31:0] v_active, v_sync_beg, v_sync_end, v_total, fb_base, burst_len;
    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vidfb_csr #(.ADDR_W(8), .FB_MASK(MASK), .FB_OFFSET(OFFS)) i_vidfb_csr (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .disp_en(disp_en), .resize_pulse(resize_pulse),
        .inval_pulse(inval_pulse), .h_active(h_active), .h_sync_beg(h_sync_beg),
        .h_sync_end(h_sync_end), .h_total(h_total), .v_active(v_active),
        .v_sync_beg(v_sync_beg), .v_sync_end(v_sync_end), .v_total(v_total),
        .fb_base(fb_base), .burst_len(burst_len)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive at falling edge, sample just after the rising edge.
    task automatic access(input logic wr, input logic rd, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R3: reset state at the ports
        check("R3 disp_en", 32'(disp_en), 32'd0);
        check("R3 h_active", h_active, 32'd640);
        check("R3 v_active", v_active, 32'd480);
        check("R3 h_total", h_total, 32'd0);
        check("R11 fb_base offset", fb_base, OFFS);
        check("R10 rdata idle", bus_rdata, 32'd0);
        check("R10 err idle", 32'(bus_err), 32'd0);

        for (int k = 0; k < NVEC; k++) begin
            access(VEC[k].wr, !VEC[k].wr, VEC[k].addr, VEC[k].data);
            check($sformatf("R%0d vec%0d rdata", VEC[k].req, k), bus_rdata, VEC[k].exp_rd);
            check($sformatf("R%0d vec%0d err", VEC[k].req, k), 32'(bus_err), 32'(VEC[k].exp_err));
            check($sformatf("R%0d vec%0d resize", VEC[k].req, k), 32'(resize_pulse), 32'(VEC[k].exp_rsz));
            check($sformatf("R%0d vec%0d inval", VEC[k].req, k), 32'(inval_pulse), 32'(VEC[k].exp_inv));
        end

        // R2: held display is off, release turns it on
        check("R2 disp_en held", 32'(disp_en), 32'd0);
        access(1'b1, 1'b0, 8'h00, 32'd0);
        check("R2 disp_en released", 32'(disp_en), 32'd1);
        check("R7 resize on release", 32'(resize_pulse), 32'd1);

        // R11: outputs follow slots
        access(1'b1, 1'b0, 8'h10, 32'd800);
        access(1'b1, 1'b0, 8'h20, 32'd525);
        check("R11 h_total", h_total, 32'd800);
        check("R11 v_total", v_total, 32'd525);
        check("R11 h_active", h_active, 32'd1024);
        check("R11 v_active", v_active, 32'd600);
        check("R11 h_sync_beg", h_sync_beg, 32'd656);
        check("R11 burst_len", burst_len, 32'd7);
        check("R11 fb_base", fb_base, 32'h120);

        // R5: pulse lasts one cycle
        access(1'b1, 1'b0, 8'h24, 32'h0000_0040);
        check("R5 inval", 32'(inval_pulse), 32'd1);
        access(1'b0, 1'b0, 8'h00, 32'd0);
        check("R5 inval one cycle", 32'(inval_pulse), 32'd0);
        check("R11 fb_base new", fb_base, 32'h140);

        // R10: error and data return to zero after an illegal read
        access(1'b0, 1'b1, 8'hF0, 32'd0);
        check("R10 err raised", 32'(bus_err), 32'd1);
        access(1'b0, 1'b0, 8'h00, 32'd0);
        check("R10 err one cycle", 32'(bus_err), 32'd0);
        check("R10 rdata after idle", bus_rdata, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule